// File: doc/BRIEF.md
# Management-Bus PHY Address Scanner

This block searches a management bus for the first transceiver that answers. On a start pulse it walks the 32 possible transceiver addresses and, for each one, asks an external management-bus master for one read of the basic status register (register 1). Each read goes out as a one-cycle request, and the block then waits for the master's completion. A response counts as a live transceiver only when the master reports no acknowledge error and the returned word is neither all zeros nor all ones.

The walk begins at address 1, climbs to 31 and tries address 0 last. The first address that passes ends the scan with a found indication and the captured 5-bit address. If every address fails, the scan ends with found low. The outcome stays on the outputs until software pulses start again. Start pulses that arrive while a scan is running are dropped.

Top module: `phy_scan`

## Requirements
- R1: Probes are issued in the order 1, 2, ..., 31, 0. Each address is probed at most once per scan, and the address is presented on `rd_phy_o` while `rd_req_o` is high.
- R2: Every probe carries register address 1 (basic status) on `rd_reg_o`.
- R3: `rd_req_o` is a single-cycle pulse. No further request is issued until `rd_done_i` has been seen for the previous one, so at most one read is outstanding.
- R4: A probe whose completion has `rd_err_i` high is treated as no transceiver, whatever its data.
- R5: A probe that completes with data 16'hFFFF or 16'h0000 is treated as no transceiver.
- R6: The first passing probe ends the scan in the cycle after its completion. At that point `done_o` is 1, `found_o` is 1, `phy_addr_o` holds the probed address, and no further requests are issued.
- R7: If all 32 probes fail, the scan ends with `done_o` = 1, `found_o` = 0 and `phy_addr_o` = 0, after exactly 32 requests.
- R8: A `start_i` pulse while `busy_o` is high has no effect on the probe sequence or on the result.
- R9: While idle, `done_o`, `found_o` and `phy_addr_o` hold their values until a start is accepted. An accepted start clears `done_o` and `found_o` and raises `busy_o` in the next cycle.
- R10: After reset, `busy_o`, `rd_req_o`, `done_o` and `found_o` are 0 and `phy_addr_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Scan start pulse |
| rd_req_o | output | 1 | Read request pulse to the management master |
| rd_phy_o | output | 5 | Transceiver address of the request |
| rd_reg_o | output | 5 | Register address of the request (always 1) |
| rd_done_i | input | 1 | Read completion from the master |
| rd_data_i | input | 16 | Read data, valid with `rd_done_i` |
| rd_err_i | input | 1 | Acknowledge failure, valid with `rd_done_i` |
| busy_o | output | 1 | Scan in progress |
| done_o | output | 1 | Scan finished, held until the next start |
| found_o | output | 1 | A transceiver was found |
| phy_addr_o | output | 5 | Address of the transceiver that was found |

## Verification
A wrong address cursor shows on the very next request: the presented address breaks the 1..31,0 order, or the scan restarts after a stray start. A faulty response filter becomes visible one cycle after the offending completion. The scan stops early with a wrong captured address, or it keeps probing past a valid transceiver. A broken handshake state either emits a second request before completion or produces a request after the outcome has been posted, so the error appears within one probe round trip.

// File: rtl/phy_scan_pkg.sv
package phy_scan_pkg;

  parameter int MDIO_ADDR_W = 5;
  parameter int MDIO_DATA_W = 16;
  parameter int MDIO_REG_W  = 5;

  typedef enum logic [1:0] {
    SC_IDLE  = 2'd0,
    SC_ISSUE = 2'd1,
    SC_WAIT  = 2'd2
  } scan_state_e;

  // Scan index k (0-based) maps to address (k+1) mod 2^W: 1..31 first, 0 last.
  function automatic logic [MDIO_ADDR_W-1:0] probe_addr(input logic [MDIO_ADDR_W-1:0] idx);
    logic [MDIO_ADDR_W:0] sum;
    sum = {1'b0, idx} + 1'b1;
    return sum[MDIO_ADDR_W-1:0];
  endfunction

  // A live transceiver acknowledged and returned a word that is not stuck.
  function automatic logic response_plausible(input logic err,
                                              input logic [MDIO_DATA_W-1:0] data);
    return !err && (data != {MDIO_DATA_W{1'b1}}) && (data != {MDIO_DATA_W{1'b0}});
  endfunction

endpackage

// File: rtl/phy_scan_cursor.sv
module phy_scan_cursor
  import phy_scan_pkg::*;
#(
  parameter int ADDR_W = MDIO_ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_i,
  input  logic              step_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              last_o
);
  localparam logic [ADDR_W-1:0] LAST_IDX = {ADDR_W{1'b1}};

  logic [ADDR_W-1:0] idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       idx_q <= '0;
    else if (clear_i) idx_q <= '0;
    else if (step_i)  idx_q <= idx_q + 1'b1;
  end

  assign addr_o = probe_addr(idx_q);
  assign last_o = (idx_q == LAST_IDX);
endmodule

// File: rtl/phy_scan_judge.sv
module phy_scan_judge
  import phy_scan_pkg::*;
#(
  parameter int DATA_W = MDIO_DATA_W
) (
  input  logic              valid_i,
  input  logic              err_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              pass_o,
  output logic              fail_o
);
  logic ok;
  assign ok     = response_plausible(err_i, data_i);
  assign pass_o = valid_i && ok;
  assign fail_o = valid_i && !ok;
endmodule

// File: rtl/phy_scan_result.sv
module phy_scan_result #(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_i,
  input  logic              hit_i,
  input  logic              exhaust_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              done_o,
  output logic              found_o,
  output logic [ADDR_W-1:0] addr_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_o  <= 1'b0;
      found_o <= 1'b0;
      addr_o  <= '0;
    end else if (clear_i) begin
      done_o  <= 1'b0;
      found_o <= 1'b0;
      addr_o  <= '0;
    end else if (hit_i) begin
      done_o  <= 1'b1;
      found_o <= 1'b1;
      addr_o  <= addr_i;
    end else if (exhaust_i) begin
      done_o  <= 1'b1;
    end
  end
endmodule

// File: rtl/phy_scan.sv
module phy_scan
  import phy_scan_pkg::*;
#(
  parameter int ADDR_W     = MDIO_ADDR_W,
  parameter int DATA_W     = MDIO_DATA_W,
  parameter int REG_W      = MDIO_REG_W,
  parameter int STATUS_REG = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  output logic              rd_req_o,
  output logic [ADDR_W-1:0] rd_phy_o,
  output logic [REG_W-1:0]  rd_reg_o,
  input  logic              rd_done_i,
  input  logic [DATA_W-1:0] rd_data_i,
  input  logic              rd_err_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              found_o,
  output logic [ADDR_W-1:0] phy_addr_o
);
  localparam logic [REG_W-1:0] REG_SEL = REG_W'(STATUS_REG);

  scan_state_e state_q, state_d;

  // Named internal events
  logic start_acc;
  logic resp_seen;
  logic probe_pass;
  logic probe_fail;
  logic cursor_last;
  logic scan_hit;
  logic scan_exhaust;
  logic scan_step;
  logic [ADDR_W-1:0] cur_addr;

  assign start_acc    = start_i && (state_q == SC_IDLE);
  assign resp_seen    = rd_done_i && (state_q == SC_WAIT);
  assign scan_hit     = probe_pass;
  assign scan_exhaust = probe_fail && cursor_last;
  assign scan_step    = probe_fail && !cursor_last;

  phy_scan_cursor #(.ADDR_W(ADDR_W)) u_cursor (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear_i (start_acc),
    .step_i  (scan_step),
    .addr_o  (cur_addr),
    .last_o  (cursor_last)
  );

  phy_scan_judge #(.DATA_W(DATA_W)) u_judge (
    .valid_i (resp_seen),
    .err_i   (rd_err_i),
    .data_i  (rd_data_i),
    .pass_o  (probe_pass),
    .fail_o  (probe_fail)
  );

  phy_scan_result #(.ADDR_W(ADDR_W)) u_result (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear_i   (start_acc),
    .hit_i     (scan_hit),
    .exhaust_i (scan_exhaust),
    .addr_i    (cur_addr),
    .done_o    (done_o),
    .found_o   (found_o),
    .addr_o    (phy_addr_o)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SC_IDLE:  if (start_acc) state_d = SC_ISSUE;
      SC_ISSUE: state_d = SC_WAIT;
      SC_WAIT: begin
        if (scan_hit || scan_exhaust) state_d = SC_IDLE;
        else if (scan_step)           state_d = SC_ISSUE;
      end
      default:  state_d = SC_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SC_IDLE;
    else        state_q <= state_d;
  end

  assign rd_req_o = (state_q == SC_ISSUE);
  assign rd_phy_o = cur_addr;
  assign rd_reg_o = REG_SEL;
  assign busy_o   = (state_q != SC_IDLE);
endmodule

// File: rtl/phy_scan_chk.sv
module phy_scan_chk #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 16,
  parameter int REG_W  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic              rd_req_o,
  input logic [ADDR_W-1:0] rd_phy_o,
  input logic [REG_W-1:0]  rd_reg_o,
  input logic              rd_done_i,
  input logic [DATA_W-1:0] rd_data_i,
  input logic              rd_err_i,
  input logic              busy_o,
  input logic              done_o,
  input logic              found_o,
  input logic [ADDR_W-1:0] phy_addr_o
);
  logic              pending_q;
  logic [ADDR_W-1:0] next_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         pending_q <= 1'b0;
    else if (rd_req_o)  pending_q <= 1'b1;
    else if (rd_done_i) pending_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        next_q <= ADDR_W'(1);
    else if (rd_req_o) next_q <= rd_phy_o + 1'b1;
    else if (!busy_o)  next_q <= ADDR_W'(1);
  end

  // R1
  order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_o |-> rd_phy_o == next_q);

  // R2
  status_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_o |-> rd_reg_o == REG_W'(1));

  // R3
  req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_o |=> !rd_req_o);

  // R3
  one_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_o |-> !pending_q && busy_o);

  // R4 R5
  hit_plausible_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(found_o) |-> $past(rd_done_i) && !$past(rd_err_i)
                       && $past(rd_data_i) != {DATA_W{1'b1}}
                       && $past(rd_data_i) != {DATA_W{1'b0}});

  // R6
  found_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    found_o |-> done_o && !busy_o && !rd_req_o);

  // R9
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !start_i) |=> $stable(done_o) && $stable(found_o) && $stable(phy_addr_o));
endmodule

bind phy_scan phy_scan_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_W(REG_W)) u_phy_scan_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start_i    (start_i),
  .rd_req_o   (rd_req_o),
  .rd_phy_o   (rd_phy_o),
  .rd_reg_o   (rd_reg_o),
  .rd_done_i  (rd_done_i),
  .rd_data_i  (rd_data_i),
  .rd_err_i   (rd_err_i),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .found_o    (found_o),
  .phy_addr_o (phy_addr_o)
);

// File: tb/test_phy_scan.sv
module test_phy_scan;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i;
  logic        rd_req_o;
  logic [4:0]  rd_phy_o;
  logic [4:0]  rd_reg_o;
  logic        rd_done_i;
  logic [15:0] rd_data_i;
  logic        rd_err_i;
  logic        busy_o;
  logic        done_o;
  logic        found_o;
  logic [4:0]  phy_addr_o;

  always #4 clk = ~clk;

  phy_scan i_phy_scan (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .rd_req_o(rd_req_o), .rd_phy_o(rd_phy_o), .rd_reg_o(rd_reg_o),
    .rd_done_i(rd_done_i), .rd_data_i(rd_data_i), .rd_err_i(rd_err_i),
    .busy_o(busy_o), .done_o(done_o), .found_o(found_o), .phy_addr_o(phy_addr_o)
  );

  int n_run  = 0;
  int n_fail = 0;
  int probes_seen;
  logic [4:0]  exp_q[$];
  logic        rsp_err[32];
  logic [15:0] rsp_data[32];

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic bit model_pass(input int a);
    return !rsp_err[a] && rsp_data[a] != 16'hFFFF && rsp_data[a] != 16'h0000;
  endfunction

  // Monitor and responder: pops the expected probe and answers after a latency.
  initial begin
    int wait_cnt = 0;
    int cur = 0;
    rd_done_i = 1'b0;
    rd_data_i = '0;
    rd_err_i  = 1'b0;
    forever begin
      @(negedge clk);
      rd_done_i = 1'b0;
      if (wait_cnt > 0) begin
        wait_cnt--;
        check(!rd_req_o, "R3", "request while read outstanding", rd_req_o, 0);
        if (wait_cnt == 0) begin
          rd_done_i = 1'b1;
          rd_err_i  = rsp_err[cur];
          rd_data_i = rsp_data[cur];
        end
      end else if (rd_req_o) begin
        probes_seen++;
        cur = int'(rd_phy_o);
        check(rd_reg_o == 5'd1, "R2", "register address", rd_reg_o, 1);
        if (exp_q.size() == 0) begin
          check(1'b0, "R6", "probe after expected end", rd_phy_o, 32);
        end else begin
          logic [4:0] e;
          e = exp_q.pop_front();
          check(rd_phy_o == e, "R1", "probe address order", rd_phy_o, e);
        end
        wait_cnt = (cur % 3) + 1;
      end
    end
  end

  task automatic fill_absent(input bit use_err);
    for (int a = 0; a < 32; a++) begin
      rsp_err[a]  = use_err;
      rsp_data[a] = use_err ? 16'h7809 : 16'hFFFF;
    end
  endtask

  task automatic run_scan(input string tag, input int mid_start);
    bit         exp_found = 1'b0;
    logic [4:0] exp_addr  = '0;
    int         exp_n     = 0;
    int         cycles    = 0;
    exp_q.delete();
    for (int k = 1; k <= 32; k++) begin
      int a = k % 32;
      exp_q.push_back(5'(a));
      exp_n++;
      if (model_pass(a)) begin
        exp_found = 1'b1;
        exp_addr  = 5'(a);
        break;
      end
    end
    probes_seen = 0;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check(busy_o && !done_o && !found_o, "R9", {tag, " start clears result"},
          {busy_o, done_o, found_o}, 3'b100);
    while (!done_o && cycles < 2000) begin
      start_i = (mid_start != 0 && cycles == mid_start);
      @(negedge clk);
      cycles++;
    end
    start_i = 1'b0;
    check(done_o, exp_found ? "R6" : "R7", {tag, " done"}, done_o, 1);
    check(found_o == exp_found, exp_found ? "R6" : "R7", {tag, " found"}, found_o, exp_found);
    check(phy_addr_o == exp_addr, exp_found ? "R6" : "R7", {tag, " address"}, phy_addr_o, exp_addr);
    check(probes_seen == exp_n, exp_found ? "R6" : "R7", {tag, " probe count"}, probes_seen, exp_n);
    repeat (15) @(negedge clk);
    check(done_o && found_o == exp_found && phy_addr_o == exp_addr && !busy_o,
          "R9", {tag, " result held"}, {done_o, found_o, phy_addr_o}, {1'b1, exp_found, exp_addr});
    check(probes_seen == exp_n, "R6", {tag, " quiet after end"}, probes_seen, exp_n);
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    n_run++;
    $display("FAIL R6 watchdog: scan did not finish, actual %0d expected %0d", 0, 1);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_n   = 1'b0;
    start_i = 1'b0;
    fill_absent(1'b1);
    repeat (3) @(negedge clk);
    // R10 reset state
    check(!busy_o && !rd_req_o && !done_o && !found_o && phy_addr_o == 0,
          "R10", "reset state", {busy_o, rd_req_o, done_o, found_o, phy_addr_o}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(!busy_o && !rd_req_o, "R10", "idle after reset", {busy_o, rd_req_o}, 0);

    // R4 R7: every address reports an acknowledge failure
    fill_absent(1'b1);
    run_scan("all-err", 0);

    // R5 R7: every address returns all ones
    fill_absent(1'b0);
    run_scan("all-ones", 0);

    // R6: transceiver at 5
    fill_absent(1'b1);
    rsp_err[5] = 1'b0; rsp_data[5] = 16'h7849;
    run_scan("at5", 0);

    // R4 R5: stuck values and error with good data are skipped
    fill_absent(1'b1);
    rsp_err[1] = 1'b0; rsp_data[1] = 16'hFFFF;
    rsp_err[2] = 1'b0; rsp_data[2] = 16'h0000;
    rsp_err[3] = 1'b1; rsp_data[3] = 16'h1234;
    rsp_err[4] = 1'b0; rsp_data[4] = 16'h0001;
    run_scan("filter", 0);

    // R1: address 0 is visited last
    fill_absent(1'b0);
    rsp_data[0] = 16'h782D;
    run_scan("only0", 0);

    // R1: 0 and 7 both live, 7 wins
    fill_absent(1'b1);
    rsp_err[0] = 1'b0; rsp_data[0] = 16'h782D;
    rsp_err[7] = 1'b0; rsp_data[7] = 16'hFFFE;
    run_scan("0and7", 0);

    // R8: start pulses mid-scan are ignored
    fill_absent(1'b1);
    rsp_err[31] = 1'b0; rsp_data[31] = 16'h8000;
    run_scan("restart-ignored", 10);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule